// File: doc/BRIEF.md
# Distributed Queue Lock Node Agent

This block is the per-node agent of a hardware queue lock whose waiters form a chain across nodes. For every lock in a small table indexed by lock number, the agent knows whether this node owns the lock and whether the local processor is inside its critical section. It also remembers at most one successor: the node whose request was forwarded here. Locally it takes acquire and release commands. From the network it takes grants and forwarded requests. It emits request messages addressed to a lock's home node and forward messages that hand the lock to another node.

Once the lock reaches this node it stays here after a release. A later local acquire then succeeds without any message. When a successor is waiting, the release hands the lock straight to that node and the home node is never involved. Outgoing messages leave through one valid/ready port. Each lock keeps its own pending flags, so nothing is buffered at the edge.

Top module: `dq_lock_agent`

## Requirements
- R1: After reset every lock is unowned: `msg_valid_o`, `granted_o` and `proto_err_o` are all low.
- R2: An acquire on an unowned lock produces exactly one request message: `msg_type_o`=0, `msg_lock_o`=lock, `msg_dst_o`=lock modulo NUM_NODES. The lock then waits for a grant.
- R3: A grant for a lock that is waiting raises `granted_o[lock]` for one cycle, in the cycle after the grant. The lock is then held and busy.
- R4: A release of a busy lock with no recorded successor keeps the lock cached and idle. A later acquire raises `granted_o[lock]` in the next cycle and sends no message.
- R5: A forwarded request for a cached idle lock at once produces a forward message: `msg_type_o`=1, `msg_lock_o`=lock, `msg_dst_o`=the requester. The lock becomes unowned, so the next acquire sends a request (R2).
- R6: A forwarded request that arrives while the lock is busy, or while this node waits for it, is recorded and sends nothing. The release of the busy lock then sends one forward message to that requester and no request message.
- R7: A second forwarded request for a lock that already has a recorded successor pulses `proto_err_o` in the next cycle. The first successor is kept.
- R8: A forwarded request for an unowned lock, or a grant for a lock that is not waiting, pulses `proto_err_o` in the next cycle and leaves the lock unowned.
- R9: When forward and request messages are pending together, forwards are presented first. A presented message stays valid until `msg_ready_i` accepts it.
- R10: An acquire on a lock that is busy gives no grant and sends no message.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acq_i | input | 1 | Local acquire command |
| acq_lock_i | input | LOCK_W | Lock number of the acquire |
| rel_i | input | 1 | Local release command |
| rel_lock_i | input | LOCK_W | Lock number of the release |
| grant_valid_i | input | 1 | Incoming grant message |
| grant_lock_i | input | LOCK_W | Lock number of the grant |
| fwd_valid_i | input | 1 | Incoming forwarded request |
| fwd_lock_i | input | LOCK_W | Lock number of the forwarded request |
| fwd_src_i | input | NODE_W | Node that asks for the lock |
| granted_o | output | NUM_LOCKS | One-cycle pulse per lock on a successful acquire |
| msg_valid_o | output | 1 | Outgoing message valid |
| msg_ready_i | input | 1 | Outgoing message accepted |
| msg_type_o | output | 1 | 0 request to home, 1 forward of lock |
| msg_lock_o | output | LOCK_W | Lock number of the message |
| msg_dst_o | output | NODE_W | Destination node |
| proto_err_o | output | 1 | One-cycle pulse on a protocol violation |

## Verification
The bench goes after the handover cases. A successor that arrives during the critical section must not get the lock early; a design that forwarded at once would hand out the lock twice. The release must then forward and not go idle, or the successor would wait forever. A cached reacquire must make no network traffic; a design that dropped the lock at release would send a stray request. Two further cases are covered. A duplicate successor must not overwrite the first, or the first waiter would be lost. With the port stalled, a forward must win over a request, or the request would reach the home node ahead of the handover.

// File: rtl/dq_lock_pkg.sv
package dq_lock_pkg;
  typedef enum logic [1:0] {
    LK_INVALID = 2'd0,
    LK_WAIT    = 2'd1,
    LK_BUSY    = 2'd2,
    LK_IDLE    = 2'd3
  } lk_state_e;

  typedef enum logic {
    MSG_REQ = 1'b0,
    MSG_FWD = 1'b1
  } msg_kind_e;
endpackage

// File: rtl/dq_lock_entry.sv
module dq_lock_entry
  import dq_lock_pkg::*;
#(
  parameter int NODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              grant_i,
  input  logic              fwd_i,
  input  logic [NODE_W-1:0] fwd_src_i,
  input  logic              rel_i,
  input  logic              acq_i,
  input  logic              pop_fwd_i,
  input  logic              pop_req_i,
  output logic              fwd_pend_o,
  output logic              req_pend_o,
  output logic [NODE_W-1:0] fwd_dst_o,
  output logic              granted_o,
  output logic              err_o
);
  lk_state_e         st_q, st_d;
  logic              sv_q, sv_d, fp_q, fp_d, rp_q, rp_d, g_d, e_d;
  logic [NODE_W-1:0] sid_q, sid_d, fd_q, fd_d;

  // events applied in order: network messages, then release, then acquire
  always_comb begin
    st_d = st_q; sv_d = sv_q; sid_d = sid_q;
    fp_d = fp_q; fd_d = fd_q; rp_d = rp_q;
    g_d = 1'b0; e_d = 1'b0;
    if (pop_fwd_i) fp_d = 1'b0;
    if (pop_req_i) rp_d = 1'b0;
    if (grant_i) begin
      if (st_d == LK_WAIT) begin
        st_d = LK_BUSY;
        g_d  = 1'b1;
      end else begin
        e_d = 1'b1;
      end
    end
    if (fwd_i) begin
      if (st_d == LK_IDLE) begin
        st_d = LK_INVALID;
        fp_d = 1'b1;
        fd_d = fwd_src_i;
      end else if (st_d == LK_INVALID || sv_d) begin
        e_d = 1'b1;
      end else begin
        sv_d  = 1'b1;
        sid_d = fwd_src_i;
      end
    end
    if (rel_i && st_d == LK_BUSY) begin
      if (sv_d) begin
        st_d = LK_INVALID;
        fp_d = 1'b1;
        fd_d = sid_d;
        sv_d = 1'b0;
      end else begin
        st_d = LK_IDLE;
      end
    end
    if (acq_i) begin
      if (st_d == LK_INVALID) begin
        st_d = LK_WAIT;
        rp_d = 1'b1;
      end else if (st_d == LK_IDLE) begin
        st_d = LK_BUSY;
        g_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= LK_INVALID; sv_q <= 1'b0; sid_q <= '0;
      fp_q <= 1'b0; fd_q <= '0; rp_q <= 1'b0;
      granted_o <= 1'b0; err_o <= 1'b0;
    end else begin
      st_q <= st_d; sv_q <= sv_d; sid_q <= sid_d;
      fp_q <= fp_d; fd_q <= fd_d; rp_q <= rp_d;
      granted_o <= g_d; err_o <= e_d;
    end
  end

  assign fwd_pend_o = fp_q;
  assign req_pend_o = rp_q;
  assign fwd_dst_o  = fd_q;
endmodule

// File: rtl/dq_msg_arb.sv
module dq_msg_arb
  import dq_lock_pkg::*;
#(
  parameter int NUM_LOCKS = 8,
  parameter int NUM_NODES = 16,
  localparam int LOCK_W = $clog2(NUM_LOCKS),
  localparam int NODE_W = $clog2(NUM_NODES)
) (
  input  logic [NUM_LOCKS-1:0]             fwd_pend_i,
  input  logic [NUM_LOCKS-1:0]             req_pend_i,
  input  logic [NUM_LOCKS-1:0][NODE_W-1:0] fwd_dst_i,
  input  logic                             ready_i,
  output logic                             valid_o,
  output logic                             kind_o,
  output logic [LOCK_W-1:0]                lock_o,
  output logic [NODE_W-1:0]                dst_o,
  output logic [NUM_LOCKS-1:0]             pop_fwd_o,
  output logic [NUM_LOCKS-1:0]             pop_req_o
);
  logic [LOCK_W-1:0] fsel, rsel;

  // lowest index wins within each class
  always_comb begin
    fsel = '0;
    rsel = '0;
    for (int i = NUM_LOCKS - 1; i >= 0; i--) begin
      if (fwd_pend_i[i]) fsel = LOCK_W'(i);
      if (req_pend_i[i]) rsel = LOCK_W'(i);
    end
  end

  always_comb begin
    valid_o = |fwd_pend_i || |req_pend_i;
    if (|fwd_pend_i) begin
      kind_o = MSG_FWD;
      lock_o = fsel;
      dst_o  = fwd_dst_i[fsel];
    end else begin
      kind_o = MSG_REQ;
      lock_o = rsel;
      dst_o  = NODE_W'(int'(rsel) % NUM_NODES);
    end
  end

  always_comb begin
    pop_fwd_o = '0;
    pop_req_o = '0;
    if (valid_o && ready_i) begin
      if (kind_o == MSG_FWD) pop_fwd_o[lock_o] = 1'b1;
      else                   pop_req_o[lock_o] = 1'b1;
    end
  end
endmodule

// File: rtl/dq_lock_agent.sv
module dq_lock_agent
  import dq_lock_pkg::*;
#(
  parameter int NUM_LOCKS = 8,
  parameter int NUM_NODES = 16,
  localparam int LOCK_W = $clog2(NUM_LOCKS),
  localparam int NODE_W = $clog2(NUM_NODES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 acq_i,
  input  logic [LOCK_W-1:0]    acq_lock_i,
  input  logic                 rel_i,
  input  logic [LOCK_W-1:0]    rel_lock_i,
  input  logic                 grant_valid_i,
  input  logic [LOCK_W-1:0]    grant_lock_i,
  input  logic                 fwd_valid_i,
  input  logic [LOCK_W-1:0]    fwd_lock_i,
  input  logic [NODE_W-1:0]    fwd_src_i,
  output logic [NUM_LOCKS-1:0] granted_o,
  output logic                 msg_valid_o,
  input  logic                 msg_ready_i,
  output logic                 msg_type_o,
  output logic [LOCK_W-1:0]    msg_lock_o,
  output logic [NODE_W-1:0]    msg_dst_o,
  output logic                 proto_err_o
);
  logic [NUM_LOCKS-1:0]             fwd_pend, req_pend, pop_fwd, pop_req, err;
  logic [NUM_LOCKS-1:0][NODE_W-1:0] fwd_dst;

  for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock
    dq_lock_entry #(.NODE_W(NODE_W)) u_entry (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .grant_i   (grant_valid_i && grant_lock_i == LOCK_W'(i)),
      .fwd_i     (fwd_valid_i && fwd_lock_i == LOCK_W'(i)),
      .fwd_src_i (fwd_src_i),
      .rel_i     (rel_i && rel_lock_i == LOCK_W'(i)),
      .acq_i     (acq_i && acq_lock_i == LOCK_W'(i)),
      .pop_fwd_i (pop_fwd[i]),
      .pop_req_i (pop_req[i]),
      .fwd_pend_o(fwd_pend[i]),
      .req_pend_o(req_pend[i]),
      .fwd_dst_o (fwd_dst[i]),
      .granted_o (granted_o[i]),
      .err_o     (err[i])
    );
  end

  dq_msg_arb #(.NUM_LOCKS(NUM_LOCKS), .NUM_NODES(NUM_NODES)) u_arb (
    .fwd_pend_i(fwd_pend),
    .req_pend_i(req_pend),
    .fwd_dst_i (fwd_dst),
    .ready_i   (msg_ready_i),
    .valid_o   (msg_valid_o),
    .kind_o    (msg_type_o),
    .lock_o    (msg_lock_o),
    .dst_o     (msg_dst_o),
    .pop_fwd_o (pop_fwd),
    .pop_req_o (pop_req)
  );

  assign proto_err_o = |err;
endmodule

// File: rtl/dq_lock_agent_chk.sv
module dq_lock_agent_chk #(
  parameter int NUM_LOCKS = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 acq_i,
  input logic                 rel_i,
  input logic                 grant_valid_i,
  input logic                 fwd_valid_i,
  input logic [NUM_LOCKS-1:0] granted_o,
  input logic                 msg_valid_o,
  input logic                 msg_ready_i,
  input logic                 proto_err_o
);
  // R9: a presented message is not withdrawn before acceptance
  a_r9_hold_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o);

  // R3, R4: a grant pulse needs a grant or an acquire one cycle earlier
  a_r3_grant_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |granted_o |-> $past(grant_valid_i || acq_i));

  // R7, R8: errors only follow network messages
  a_r8_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |-> $past(grant_valid_i || fwd_valid_i));

  // R2, R5, R6: new traffic only follows a local command or a forwarded request
  a_r2_msg_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msg_valid_o) |-> $past(acq_i || rel_i || fwd_valid_i));
endmodule

bind dq_lock_agent dq_lock_agent_chk #(.NUM_LOCKS(NUM_LOCKS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .acq_i        (acq_i),
  .rel_i        (rel_i),
  .grant_valid_i(grant_valid_i),
  .fwd_valid_i  (fwd_valid_i),
  .granted_o    (granted_o),
  .msg_valid_o  (msg_valid_o),
  .msg_ready_i  (msg_ready_i),
  .proto_err_o  (proto_err_o)
);

// File: tb/sim_dq_lock_agent.sv
`timescale 1ns/1ps
module sim_dq_lock_agent;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 8;
  localparam int NN = 16;
  localparam int LW = $clog2(NL);
  localparam int NW = $clog2(NN);

  logic clk = 1'b0, rst_n = 1'b0;
  logic acq = 0, rel = 0, gnt = 0, fwd = 0, ready = 1;
  logic [LW-1:0] acq_l = '0, rel_l = '0, gnt_l = '0, fwd_l = '0;
  logic [NW-1:0] fwd_s = '0;
  logic [NL-1:0] granted;
  logic m_valid, m_type, perr;
  logic [LW-1:0] m_lock;
  logic [NW-1:0] m_dst;

  typedef struct packed { logic t; logic [LW-1:0] l; logic [NW-1:0] d; } exp_t;
  exp_t exp_q[$];
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dq_lock_agent #(.NUM_LOCKS(NL), .NUM_NODES(NN)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .acq_i(acq), .acq_lock_i(acq_l), .rel_i(rel), .rel_lock_i(rel_l),
    .grant_valid_i(gnt), .grant_lock_i(gnt_l),
    .fwd_valid_i(fwd), .fwd_lock_i(fwd_l), .fwd_src_i(fwd_s),
    .granted_o(granted), .msg_valid_o(m_valid), .msg_ready_i(ready),
    .msg_type_o(m_type), .msg_lock_o(m_lock), .msg_dst_o(m_dst),
    .proto_err_o(perr));

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic push_exp(input logic t, input int l, input int d);
    exp_q.push_back('{t: t, l: LW'(l), d: NW'(d)});
  endtask

  // monitor: scoreboard pop on each accepted message
  always begin
    @(negedge clk);
    #1;
    if (rst_n && m_valid && ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2/R4/R6 unexpected message", {m_type, m_lock, m_dst}, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(m_type == e.t && m_lock == e.l && m_dst == e.d, "R2/R5/R6/R9 message",
              {m_type, m_lock, m_dst}, {e.t, e.l, e.d});
      end
    end
  end

  task automatic do_acq(input int l);
    acq = 1; acq_l = LW'(l); @(negedge clk); acq = 0;
  endtask
  task automatic do_rel(input int l);
    rel = 1; rel_l = LW'(l); @(negedge clk); rel = 0;
  endtask
  task automatic do_gnt(input int l);
    gnt = 1; gnt_l = LW'(l); @(negedge clk); gnt = 0;
  endtask
  task automatic do_fwd(input int l, input int s);
    fwd = 1; fwd_l = LW'(l); fwd_s = NW'(s); @(negedge clk); fwd = 0;
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(2);
    // R1 reset state
    check(m_valid == 0 && granted == 0 && perr == 0, "R1", {m_valid, perr}, 0);
    rst_n = 1;
    idle(1);

    // R2 request to home, R3 grant
    push_exp(1'b0, 3, 3);
    do_acq(3);
    check(granted == 0, "R2 no grant yet", granted, 0);
    idle(1);
    do_gnt(3);
    check(granted == 8'h08, "R3", granted, 8'h08);
    idle(1);
    check(granted == 0, "R3 single pulse", granted, 0);

    // R4 cached reacquire, R10 acquire while busy
    do_rel(3);
    check(m_valid == 0, "R4 release idle", m_valid, 0);
    do_acq(3);
    check(granted == 8'h08 && m_valid == 0, "R4", granted, 8'h08);
    do_acq(3);
    check(granted == 0 && m_valid == 0, "R10", granted, 0);

    // R6 successor stored during critical section
    do_fwd(3, 9);
    check(m_valid == 0, "R6 held until release", m_valid, 0);
    push_exp(1'b1, 3, 9);
    do_rel(3);
    idle(1);
    // R5 lock gone: acquire sends a request again
    push_exp(1'b0, 3, 3);
    do_acq(3);
    idle(1);
    do_gnt(3);
    check(granted == 8'h08, "R3 regrant", granted, 8'h08);
    do_rel(3);
    push_exp(1'b1, 3, 7);
    do_fwd(3, 7);
    check(m_valid == 1 && m_type == 1, "R5 immediate forward", m_type, 1);
    idle(1);

    // R7 duplicate successor
    push_exp(1'b0, 1, 1);
    do_acq(1);
    idle(1);
    do_gnt(1);
    do_fwd(1, 2);
    check(perr == 0 && m_valid == 0, "R6 stored", perr, 0);
    do_fwd(1, 4);
    check(perr == 1, "R7 error pulse", perr, 1);
    push_exp(1'b1, 1, 2);
    do_rel(1);
    check(perr == 0, "R7 pulse ends", perr, 0);
    idle(1);

    // R6 successor recorded while waiting for grant
    push_exp(1'b0, 4, 4);
    do_acq(4);
    do_fwd(4, 13);
    check(perr == 0, "R6 wait stored", perr, 0);
    do_gnt(4);
    check(granted == 8'h10, "R3 lock4", granted, 8'h10);
    push_exp(1'b1, 4, 13);
    do_rel(4);
    idle(1);

    // R8 protocol errors on unowned lock
    do_fwd(6, 5);
    check(perr == 1 && m_valid == 0, "R8 fwd unowned", perr, 1);
    do_gnt(6);
    check(perr == 1 && granted == 0, "R8 stray grant", perr, 1);
    push_exp(1'b0, 6, 6);
    do_acq(6);
    check(granted == 0, "R8 lock stays unowned", granted, 0);
    idle(1);

    // R9 forward beats request under backpressure
    push_exp(1'b0, 5, 5);
    do_acq(5);
    idle(1);
    do_gnt(5);
    do_rel(5);
    ready = 0;
    push_exp(1'b1, 5, 11);
    push_exp(1'b0, 2, 2);
    do_acq(2);
    do_fwd(5, 11);
    idle(2);
    check(m_valid == 1 && m_type == 1 && m_lock == 5, "R9 forward first", m_lock, 5);
    ready = 1;
    idle(4);
    check(m_valid == 0, "R9 drained", m_valid, 0);
    check(exp_q.size() == 0, "R2/R9 all messages seen", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule